// File: doc/BRIEF.md
# Removable Memory Card Bus Decoder

This block sits between the 16-bit host bus of a removable memory card and the card's storage. The storage is eight pairs of 8-bit flash segments and a small byte-wide attribute memory. On every clock it samples the host's active-low card enables, output enable, write enable and register-space select. It also samples the lowest address bit, the segment-pair address bits and the write-protect switch. From these it produces registered selects for the storage and controls for the data transceivers.

The decoder chooses among five cases: standby, even-byte, odd-byte-swapped, odd-byte-on-high-lane and full-word access. In each case it enables exactly the flash segments and data lanes that the access needs. For an odd byte read through the low card enable, it asserts a swap select so the high segment's byte lands on the low lane. When register space is selected, the flash segments stay idle and only the attribute memory is enabled. Attribute data is byte-wide and appears only on the low lane.

Two conditions block writes. A set write-protect switch suppresses every flash write strobe and raises a status output. Simultaneous output and write enables count as an illegal cycle, which drives no lane and issues no strobe. All outputs are registered, so each one reflects the inputs sampled at the previous clock edge. The card-detect outputs are tied low and the battery-status outputs are tied high.

Top module: `cdec_top`

## Requirements
- R1: With both card enables high, every segment enable, the attribute enable and both lane enables are high (inactive), and swap select is 0. This is also the state held during reset.
- R2: With ce1_n=0, ce2_n=1, a0=0 and reg_n=1, only the low segment of the pair addressed by a_pair is enabled (seg_lo_ce_n bit a_pair low). Only the low lane can be enabled, and swap select is 0.
- R3: With ce1_n=0, ce2_n=1, a0=1 and reg_n=1, only the high segment of the addressed pair is enabled. Swap select is 1, and only the low lane can be enabled.
- R4: With ce1_n=1, ce2_n=0 and reg_n=1, only the high segment of the addressed pair and the high lane are used, whatever the value of a0.
- R5: With both card enables low and reg_n=1, both segments of the addressed pair and both lanes are used, and a0 has no effect.
- R6: At most two segment enables are active in any cycle, both belonging to the addressed pair, and all other pairs stay deselected.
- R7: A lane used by the access is enabled (active low) when exactly one of oe_n and we_n is low. lane_to_host is 1 for a read (oe_n=0, we_n=1) and 0 otherwise. With both strobes high, no lane is enabled. A write (oe_n=1, we_n=0) to flash pulls flash_we_n low.
- R8: With reg_n=0 and any card enable low, attr_ce_n is low and no flash segment is enabled. The high lane is never enabled and swap select stays 0. The low lane and attr_we_n are used only when ce1_n=0, and flash_we_n stays high.
- R9: With wp_sw=1, flash_we_n stays high for every input combination and wp_status reads 1. Attribute writes are not blocked.
- R10: With oe_n=0 and we_n=0 together, both lane enables, flash_we_n and attr_we_n stay high.
- R11: card_det_n is constantly 2'b00, and batt_ok is constantly 2'b11.
- R12: Every decoded output changes only at a clock edge and reflects the inputs sampled at that edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce1_n | input | 1 | Card enable for the low byte path, active low |
| ce2_n | input | 1 | Card enable for the high byte path, active low |
| oe_n | input | 1 | Host read strobe, active low |
| we_n | input | 1 | Host write strobe, active low |
| reg_n | input | 1 | Register (attribute) space select, active low |
| a0 | input | 1 | Byte address bit |
| a_pair | input | PAIR_W | Segment-pair select address |
| wp_sw | input | 1 | Write-protect switch, 1 = protected |
| seg_lo_ce_n | output | NUM_PAIRS | Even-byte segment enables, active low |
| seg_hi_ce_n | output | NUM_PAIRS | Odd-byte segment enables, active low |
| attr_ce_n | output | 1 | Attribute memory enable, active low |
| lo_lane_oe_n | output | 1 | Low data lane transceiver enable, active low |
| hi_lane_oe_n | output | 1 | High data lane transceiver enable, active low |
| lane_to_host | output | 1 | Transceiver direction, 1 = toward host |
| byte_swap | output | 1 | Route high segment byte onto low lane |
| flash_we_n | output | 1 | Gated flash write strobe, active low |
| attr_we_n | output | 1 | Gated attribute write strobe, active low |
| wp_status | output | 1 | Write-protect status to host |
| card_det_n | output | 2 | Card-detect outputs, tied low |
| batt_ok | output | 2 | Battery-status outputs, tied high |

## Verification
The assertions check, on every cycle, that the registered outputs remain mutually consistent. No more than two segments are active, and both belong to one pair. Protection never coexists with a flash strobe. A swap never coexists with a high-lane enable. An attribute access never touches the high lane or a flash segment. A write strobe never coexists with the host-facing direction. Only the bench can show that each mode selects the right pair and lane, and that a0 is ignored in word and high-lane modes. It also shows the one-cycle latency and the tied-off status pins, by comparing every output against a model driven with random and directed patterns.

// File: rtl/cdec_pkg.sv
package cdec_pkg;
  typedef enum logic [2:0] {
    M_IDLE,
    M_EVEN,
    M_ODD_SW,
    M_ODD_HI,
    M_WORD,
    M_ATTR_LO,
    M_ATTR_HI
  } acc_mode_e;

  typedef struct packed {
    logic lo_lane;
    logic hi_lane;
    logic to_host;
    logic swap;
    logic flash_we;
    logic attr_we;
    logic attr_sel;
  } lane_ctl_t;
endpackage

// File: rtl/cdec_mode.sv
module cdec_mode
  import cdec_pkg::*;
(
  input  logic      ce1_n,
  input  logic      ce2_n,
  input  logic      reg_n,
  input  logic      a0,
  output acc_mode_e mode
);
  always_comb begin
    if (ce1_n && ce2_n)       mode = M_IDLE;
    else if (!reg_n)          mode = ce1_n ? M_ATTR_HI : M_ATTR_LO;
    else if (!ce1_n && !ce2_n) mode = M_WORD;
    else if (!ce1_n)          mode = a0 ? M_ODD_SW : M_EVEN;
    else                      mode = M_ODD_HI;
  end
endmodule

// File: rtl/cdec_seg_sel.sv
module cdec_seg_sel
  import cdec_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  acc_mode_e         mode,
  input  logic [PAIR_W-1:0] a_pair,
  output logic [NUM_PAIRS-1:0] lo_en,
  output logic [NUM_PAIRS-1:0] hi_en
);
  logic use_lo, use_hi;

  always_comb begin
    use_lo = (mode == M_EVEN) || (mode == M_WORD);
    use_hi = (mode == M_ODD_SW) || (mode == M_ODD_HI) || (mode == M_WORD);
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic hit;
    assign hit      = (a_pair == PAIR_W'(p));
    assign lo_en[p] = hit && use_lo;
    assign hi_en[p] = hit && use_hi;
  end
endmodule

// File: rtl/cdec_lane_ctl.sv
module cdec_lane_ctl
  import cdec_pkg::*;
(
  input  acc_mode_e mode,
  input  logic      oe_n,
  input  logic      we_n,
  input  logic      wp_sw,
  output lane_ctl_t ctl
);
  logic rd, wr, xfer, flash_mode;

  always_comb begin
    rd         = !oe_n && we_n;
    wr         = oe_n && !we_n;
    xfer       = rd || wr;
    flash_mode = (mode == M_EVEN) || (mode == M_ODD_SW) ||
                 (mode == M_ODD_HI) || (mode == M_WORD);

    ctl.lo_lane  = xfer && ((mode == M_EVEN) || (mode == M_ODD_SW) ||
                            (mode == M_WORD) || (mode == M_ATTR_LO));
    ctl.hi_lane  = xfer && ((mode == M_ODD_HI) || (mode == M_WORD));
    ctl.to_host  = rd && (ctl.lo_lane || ctl.hi_lane);
    ctl.swap     = (mode == M_ODD_SW);
    ctl.flash_we = wr && flash_mode && !wp_sw;
    ctl.attr_we  = wr && (mode == M_ATTR_LO);
    ctl.attr_sel = (mode == M_ATTR_LO) || (mode == M_ATTR_HI);
  end
endmodule

// File: rtl/cdec_top.sv
module cdec_top
  import cdec_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce1_n,
  input  logic                 ce2_n,
  input  logic                 oe_n,
  input  logic                 we_n,
  input  logic                 reg_n,
  input  logic                 a0,
  input  logic [PAIR_W-1:0]    a_pair,
  input  logic                 wp_sw,
  output logic [NUM_PAIRS-1:0] seg_lo_ce_n,
  output logic [NUM_PAIRS-1:0] seg_hi_ce_n,
  output logic                 attr_ce_n,
  output logic                 lo_lane_oe_n,
  output logic                 hi_lane_oe_n,
  output logic                 lane_to_host,
  output logic                 byte_swap,
  output logic                 flash_we_n,
  output logic                 attr_we_n,
  output logic                 wp_status,
  output logic [1:0]           card_det_n,
  output logic [1:0]           batt_ok
);
  acc_mode_e            mode;
  logic [NUM_PAIRS-1:0] lo_en, hi_en;
  lane_ctl_t            ctl;

  cdec_mode u_mode (
    .ce1_n (ce1_n),
    .ce2_n (ce2_n),
    .reg_n (reg_n),
    .a0    (a0),
    .mode  (mode)
  );

  cdec_seg_sel #(.NUM_PAIRS(NUM_PAIRS)) u_seg (
    .mode   (mode),
    .a_pair (a_pair),
    .lo_en  (lo_en),
    .hi_en  (hi_en)
  );

  cdec_lane_ctl u_lane (
    .mode  (mode),
    .oe_n  (oe_n),
    .we_n  (we_n),
    .wp_sw (wp_sw),
    .ctl   (ctl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_lo_ce_n  <= '1;
      seg_hi_ce_n  <= '1;
      attr_ce_n    <= 1'b1;
      lo_lane_oe_n <= 1'b1;
      hi_lane_oe_n <= 1'b1;
      lane_to_host <= 1'b0;
      byte_swap    <= 1'b0;
      flash_we_n   <= 1'b1;
      attr_we_n    <= 1'b1;
      wp_status    <= 1'b0;
    end else begin
      seg_lo_ce_n  <= ~lo_en;
      seg_hi_ce_n  <= ~hi_en;
      attr_ce_n    <= ~ctl.attr_sel;
      lo_lane_oe_n <= ~ctl.lo_lane;
      hi_lane_oe_n <= ~ctl.hi_lane;
      lane_to_host <= ctl.to_host;
      byte_swap    <= ctl.swap;
      flash_we_n   <= ~ctl.flash_we;
      attr_we_n    <= ~ctl.attr_we;
      wp_status    <= wp_sw;
    end
  end

  assign card_det_n = 2'b00;
  assign batt_ok    = 2'b11;

  // R6: no more than one pair's segments active at once
  p_seg_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~seg_lo_ce_n) + $countones(~seg_hi_ce_n)) <= 2);
  p_seg_same_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(~seg_lo_ce_n) && $onehot0(~seg_hi_ce_n) &&
     ((seg_lo_ce_n == '1) || (seg_hi_ce_n == '1) || (seg_lo_ce_n == seg_hi_ce_n))));
  // R9: protection blocks the flash strobe
  p_wp_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wp_status |-> flash_we_n);
  // R3: swapped odd byte never uses the high lane
  p_swap_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_swap |-> hi_lane_oe_n);
  // R8: attribute access keeps flash and high lane idle
  p_attr_iso_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !attr_ce_n |-> (hi_lane_oe_n && !byte_swap && flash_we_n &&
                    (seg_lo_ce_n == '1) && (seg_hi_ce_n == '1)));
  // R7: a write strobe never coincides with driving toward the host
  p_write_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n || !attr_we_n) |-> !lane_to_host);
  // R10: host-facing direction only with a lane enabled
  p_dir_lane_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lane_to_host |-> (!lo_lane_oe_n || !hi_lane_oe_n));
endmodule

// File: tb/sim_cdec_top.sv
module sim_cdec_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce1_n = 1, ce2_n = 1, oe_n = 1, we_n = 1, reg_n = 1, a0 = 0, wp_sw = 0;
  logic [2:0] a_pair = '0;
  logic [7:0] seg_lo_ce_n, seg_hi_ce_n;
  logic attr_ce_n, lo_lane_oe_n, hi_lane_oe_n, lane_to_host, byte_swap;
  logic flash_we_n, attr_we_n, wp_status;
  logic [1:0] card_det_n, batt_ok;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cdec_top u0 (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .oe_n(oe_n),
    .we_n(we_n), .reg_n(reg_n), .a0(a0), .a_pair(a_pair), .wp_sw(wp_sw),
    .seg_lo_ce_n(seg_lo_ce_n), .seg_hi_ce_n(seg_hi_ce_n), .attr_ce_n(attr_ce_n),
    .lo_lane_oe_n(lo_lane_oe_n), .hi_lane_oe_n(hi_lane_oe_n),
    .lane_to_host(lane_to_host), .byte_swap(byte_swap), .flash_we_n(flash_we_n),
    .attr_we_n(attr_we_n), .wp_status(wp_status), .card_det_n(card_det_n),
    .batt_ok(batt_ok)
  );

  function automatic logic [23:0] model(input logic c1, c2, oe, we, rg, b0,
                                        input logic [2:0] pr, input logic wp);
    logic [7:0] lo, hi;
    logic attr, lol, hil, dir, sw, fwe, awe, any, rd, wr;
    lo = '0; hi = '0; attr = 0; lol = 0; hil = 0; sw = 0; fwe = 0; awe = 0;
    any = !c1 || !c2;
    rd  = !oe && we;
    wr  = oe && !we;
    if (any && !rg) begin
      attr = 1;
      lol  = (rd || wr) && !c1;
      awe  = wr && !c1;
    end else if (any) begin
      if (!c1 && !c2) begin
        lo[pr] = 1; hi[pr] = 1; lol = rd || wr; hil = lol;
      end else if (!c1) begin
        if (b0) begin hi[pr] = 1; sw = 1; end
        else lo[pr] = 1;
        lol = rd || wr;
      end else begin
        hi[pr] = 1; hil = rd || wr;
      end
      fwe = wr && !wp;
    end
    dir = rd && (lol || hil);
    return {~lo, ~hi, ~attr, ~lol, ~hil, dir, sw, ~fwe, ~awe, wp};
  endfunction

  function automatic string req_of(input logic c1, c2, oe, we, rg, b0, wp);
    if (c1 && c2) return "R1";
    if (!rg) return "R8";
    if (!oe && !we) return "R10";
    if (wp && !we) return "R9";
    if (!c1 && !c2) return "R5";
    if (!c1) return b0 ? "R3" : "R2";
    return "R4";
  endfunction

  function automatic logic [23:0] dut_vec();
    return {seg_lo_ce_n, seg_hi_ce_n, attr_ce_n, lo_lane_oe_n, hi_lane_oe_n,
            lane_to_host, byte_swap, flash_we_n, attr_we_n, wp_status};
  endfunction

  task automatic cmp(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge register it, check at the next falling edge
  task automatic apply(input string tag, input logic c1, c2, oe, we, rg, b0,
                       input logic [2:0] pr, input logic wp);
    ce1_n = c1; ce2_n = c2; oe_n = oe; we_n = we; reg_n = rg; a0 = b0;
    a_pair = pr; wp_sw = wp;
    @(posedge clk);
    @(negedge clk);
    cmp(tag, dut_vec(), model(c1, c2, oe, we, rg, b0, pr, wp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] prev;
    void'($urandom(32'd2024));
    // reset state; inputs request a word read, which reset must override (R1)
    ce1_n = 0; ce2_n = 0; oe_n = 0;
    repeat (3) @(negedge clk);
    cmp("R1 reset", dut_vec(), {8'hFF, 8'hFF, 8'b1110_0110});
    rst_n = 1;
    apply("R1 standby", 1, 1, 0, 1, 1, 0, 3'd2, 0);
    apply("R2 even read", 0, 1, 0, 1, 1, 0, 3'd3, 0);
    apply("R3 odd swap read", 0, 1, 0, 1, 1, 1, 3'd6, 0);
    apply("R4 high lane a0=0", 1, 0, 0, 1, 1, 0, 3'd1, 0);
    apply("R4 high lane a0=1", 1, 0, 0, 1, 1, 1, 3'd1, 0);
    apply("R5 word a0=1", 0, 0, 0, 1, 1, 1, 3'd7, 0);
    apply("R5 word write a0=0", 0, 0, 1, 0, 1, 0, 3'd0, 0);
    // R6: word access to pair 5 enables exactly the two segments of pair 5
    apply("R6 pair 5", 0, 0, 1, 1, 1, 0, 3'd5, 0);
    cmp("R6 lo only pair5", {16'd0, seg_lo_ce_n}, {16'd0, 8'b1101_1111});
    cmp("R6 hi only pair5", {16'd0, seg_hi_ce_n}, {16'd0, 8'b1101_1111});
    apply("R7 write even", 0, 1, 1, 0, 1, 0, 3'd4, 0);
    apply("R7 no strobe", 0, 1, 1, 1, 1, 0, 3'd4, 0);
    apply("R8 attr read", 0, 1, 0, 1, 0, 1, 3'd2, 0);
    apply("R8 attr write", 0, 0, 1, 0, 0, 0, 3'd2, 1);
    apply("R8 attr via ce2", 1, 0, 1, 0, 0, 0, 3'd2, 0);
    apply("R9 protected word write", 0, 0, 1, 0, 1, 0, 3'd3, 1);
    apply("R9 protected odd write", 1, 0, 1, 0, 1, 1, 3'd3, 1);
    apply("R10 both strobes", 0, 0, 0, 0, 1, 0, 3'd1, 0);
    apply("R10 both strobes attr", 0, 1, 0, 0, 0, 0, 3'd1, 0);
    cmp("R11 ties", {20'd0, card_det_n, batt_ok}, {20'd0, 2'b00, 2'b11});
    // R12: a new input pattern must not show before the next rising edge
    prev = dut_vec();
    ce1_n = 0; ce2_n = 1; oe_n = 0; we_n = 1; reg_n = 1; a0 = 0; a_pair = 3'd6; wp_sw = 0;
    #(CLK_P/4);
    cmp("R12 hold before edge", dut_vec(), prev);
    @(posedge clk);
    @(negedge clk);
    cmp("R12 update after edge", dut_vec(), model(0, 1, 0, 1, 1, 0, 3'd6, 0));
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [9:0] r;
      r = 10'($urandom());
      apply(req_of(r[0], r[1], r[2], r[3], r[4], r[5], r[9]),
            r[0], r[1], r[2], r[3], r[4] | ($urandom_range(0, 3) != 0), r[5],
            r[8:6], r[9]);
    end
    cmp("R11 ties end", {20'd0, card_det_n, batt_ok}, {20'd0, 2'b00, 2'b11});
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule